// File: doc/BRIEF.md
# Soft-Start Demand and Current-Limit Sequencer

This block governs the startup of a sensorless three-phase fan drive. When it is enabled, it raises a current-limit code through a fixed schedule. The current limit starts low and climbs one 50 mA unit at a time until it reaches its ceiling. For this schedule the block offers a slow rate and a fast rate. During the trapezoidal spin-up phase the speed demand handed to the modulator never drops below half scale, so the rotor accelerates in bounded time. An external demand above that floor passes through unchanged.

Once the drive reports that it has moved to sinusoidal commutation, the sequencer waits for a hold interval. It then lowers the applied demand by one count per step period until the demand meets the external value, and from then on it follows that value. If the drive flags a locked rotor, the sequencer removes drive enable for a fixed lockout time and then restarts the whole soft start. When enable is removed, the block returns to an idle state with the demand at zero.

All intervals are counted in ticks of a millisecond strobe. The schedule lengths, the floor and the current-limit range are parameters.

Top module: `ss_softstart_seq`

## Requirements
- R1: The current-limit code `ilim_code` is `ILIM_START` whenever a soft start begins. While the drive is active, the code rises by exactly 1 after every `SLOW_MS` ticks when `fast_sel`=0, or after every `FAST_MS` ticks when `fast_sel`=1.
- R2: `ilim_code` stops at `ILIM_MAX` and never goes above it.
- R3: In the startup state and the hold state, `applied_demand` is the larger of `ext_demand` and `FLOOR`, and it is updated one clock after `ext_demand`.
- R4: A one-cycle pulse on `mode_sw` starts a hold of `HOLD_MS` ticks. After the hold, while `applied_demand` is above `ext_demand`, it falls by one count every `STEP_MS` ticks.
- R5: During the downward ramp, once `ext_demand` is equal to or above `applied_demand`, the block enters the run state. In the run state `applied_demand` equals `ext_demand` one clock later.
- R6: `lock_det` in any active state forces `drive_en`=0 and `applied_demand`=0 for `LOCK_MS` ticks. Pulses on `lock_det` during that time do not extend it. On the last tick the block restarts with `drive_en`=1, the floor rule of R3 and `ilim_code`=`ILIM_START`.
- R7: With `en`=0 the block goes idle: `drive_en`=0, `applied_demand`=0, and `ilim_code`=`ILIM_START` from the second clock on. Raising `en` from idle starts a soft start on the next clock.
- R8: Following reset the block is idle, with `drive_en`=0, `applied_demand`=0 and `ilim_code`=`ILIM_START`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable |
| fast_sel | input | 1 | 1 selects the fast current-limit schedule |
| ext_demand | input | DEM_W | External speed demand |
| mode_sw | input | 1 | Pulse: drive has moved to sinusoidal mode |
| lock_det | input | 1 | Pulse: locked rotor detected |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| applied_demand | output | DEM_W | Demand passed to the modulator |
| ilim_code | output | ILIM_W | Current limit in 50 mA units |
| drive_en | output | 1 | Output stage enable |

## Verification
The bench shrinks the schedule parameters: slow step 6, fast step 3, hold 10, ramp step 2, lockout 20 and a current-limit ceiling of 8. With these values every phase boundary, the current-limit cap, a complete ramp down to a demand below the floor, and a full lockout-and-restart cycle all fit in a few hundred ticks. The floor and the demand width keep their default values, so the floor comparison is checked at its real size.

// File: rtl/ss_pkg.sv
package ss_pkg;
    typedef enum logic [2:0] {
        SS_IDLE  = 3'd0,
        SS_START = 3'd1,
        SS_HOLD  = 3'd2,
        SS_RAMP  = 3'd3,
        SS_RUN   = 3'd4,
        SS_LOCK  = 3'd5
    } ss_state_e;

    function automatic logic ss_active(ss_state_e s);
        return (s == SS_START) || (s == SS_HOLD) || (s == SS_RAMP) || (s == SS_RUN);
    endfunction
endpackage

// File: rtl/ss_phase_timer.sv
module ss_phase_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick && cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/ss_ilim_stepper.sv
module ss_ilim_stepper #(
    parameter int ILIM_W     = 6,
    parameter int ILIM_START = 2,
    parameter int ILIM_MAX   = 32,
    parameter int SLOW_MS    = 128,
    parameter int FAST_MS    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              fast_sel,
    output logic [ILIM_W-1:0] ilim
);
    localparam int PER_MAX = (SLOW_MS > FAST_MS) ? SLOW_MS : FAST_MS;
    localparam int PCNT_W  = $clog2(PER_MAX + 1);
    localparam logic [PCNT_W-1:0] SLOW_LAST = PCNT_W'(SLOW_MS - 1);
    localparam logic [PCNT_W-1:0] FAST_LAST = PCNT_W'(FAST_MS - 1);
    localparam logic [ILIM_W-1:0] CODE_LO   = ILIM_W'(ILIM_START);
    localparam logic [ILIM_W-1:0] CODE_HI   = ILIM_W'(ILIM_MAX);

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
        logic [ILIM_W-1:0] code;
    } stp_t;

    stp_t stp_d, stp_q;
    logic [PCNT_W-1:0] last;

    always_comb begin
        last  = fast_sel ? FAST_LAST : SLOW_LAST;
        stp_d = stp_q;
        if (!run) begin
            stp_d.pcnt = '0;
            stp_d.code = CODE_LO;
        end else if (tick) begin
            if (stp_q.pcnt >= last) begin
                stp_d.pcnt = '0;
                if (stp_q.code < CODE_HI)
                    stp_d.code = stp_q.code + 1'b1;
            end else begin
                stp_d.pcnt = stp_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stp_q.pcnt <= '0;
            stp_q.code <= CODE_LO;
        end else begin
            stp_q <= stp_d;
        end
    end

    assign ilim = stp_q.code;

    p_ilim_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stp_q.code >= CODE_LO) && (stp_q.code <= CODE_HI));
endmodule

// File: rtl/ss_softstart_seq.sv
module ss_softstart_seq #(
    parameter int DEM_W      = 9,
    parameter int ILIM_W     = 6,
    parameter int ILIM_START = 2,
    parameter int ILIM_MAX   = 32,
    parameter int SLOW_MS    = 128,
    parameter int FAST_MS    = 31,
    parameter int HOLD_MS    = 500,
    parameter int STEP_MS    = 8,
    parameter int LOCK_MS    = 8000,
    parameter int FLOOR      = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fast_sel,
    input  logic [DEM_W-1:0]  ext_demand,
    input  logic              mode_sw,
    input  logic              lock_det,
    input  logic              ms_tick,
    output logic [DEM_W-1:0]  applied_demand,
    output logic [ILIM_W-1:0] ilim_code,
    output logic              drive_en
);
    import ss_pkg::*;

    localparam int TMAX  = (LOCK_MS > HOLD_MS) ? ((LOCK_MS > STEP_MS) ? LOCK_MS : STEP_MS)
                                               : ((HOLD_MS > STEP_MS) ? HOLD_MS : STEP_MS);
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(HOLD_MS - 1);
    localparam logic [TMR_W-1:0] STEP_LAST = TMR_W'(STEP_MS - 1);
    localparam logic [TMR_W-1:0] LOCK_LAST = TMR_W'(LOCK_MS - 1);
    localparam logic [DEM_W-1:0] FLOOR_V   = DEM_W'(FLOOR);

    typedef struct packed {
        ss_state_e        st;
        logic [DEM_W-1:0] dem;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [TMR_W-1:0] tmr;
    logic [DEM_W-1:0] floor_dem;
    logic             tmr_clr, step_now, hold_exp, step_exp, lock_exp;

    ss_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (ms_tick),
        .cnt   (tmr)
    );

    ss_ilim_stepper #(
        .ILIM_W     (ILIM_W),
        .ILIM_START (ILIM_START),
        .ILIM_MAX   (ILIM_MAX),
        .SLOW_MS    (SLOW_MS),
        .FAST_MS    (FAST_MS)
    ) u_ilim (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ss_active(seq_q.st)),
        .tick     (ms_tick),
        .fast_sel (fast_sel),
        .ilim     (ilim_code)
    );

    always_comb begin
        floor_dem = (ext_demand > FLOOR_V) ? ext_demand : FLOOR_V;
        hold_exp  = ms_tick && (tmr >= HOLD_LAST);
        step_exp  = ms_tick && (tmr >= STEP_LAST);
        lock_exp  = ms_tick && (tmr >= LOCK_LAST);
        step_now  = 1'b0;
        seq_d     = seq_q;
        unique case (seq_q.st)
            SS_IDLE: begin
                if (en) begin
                    seq_d.st  = SS_START;
                    seq_d.dem = floor_dem;
                end
            end
            SS_START: begin
                seq_d.dem = floor_dem;
                if (mode_sw) seq_d.st = SS_HOLD;
            end
            SS_HOLD: begin
                seq_d.dem = floor_dem;
                if (hold_exp) seq_d.st = SS_RAMP;
            end
            SS_RAMP: begin
                if (ext_demand >= seq_q.dem) begin
                    seq_d.dem = ext_demand;
                    seq_d.st  = SS_RUN;
                end else if (step_exp) begin
                    seq_d.dem = seq_q.dem - 1'b1;
                    step_now  = 1'b1;
                end
            end
            SS_RUN: seq_d.dem = ext_demand;
            SS_LOCK: begin
                seq_d.dem = '0;
                if (lock_exp) begin
                    seq_d.st  = SS_START;
                    seq_d.dem = floor_dem;
                end
            end
            default: begin
                seq_d.st  = SS_IDLE;
                seq_d.dem = '0;
            end
        endcase
        if (ss_active(seq_q.st) && lock_det) begin
            seq_d.st  = SS_LOCK;
            seq_d.dem = '0;
        end
        if (!en) begin
            seq_d.st  = SS_IDLE;
            seq_d.dem = '0;
        end
        tmr_clr = (seq_d.st != seq_q.st) || step_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= SS_IDLE;
            seq_q.dem <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign applied_demand = seq_q.dem;
    assign drive_en       = ss_active(seq_q.st);

    // R1: while staying active, the limit code moves up by at most one per clock
    p_ilim_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_active(seq_q.st) && $past(ss_active(seq_q.st)))
        |-> (ilim_code == $past(ilim_code)) || (ilim_code == $past(ilim_code) + 1'b1));

    p_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == SS_START) || (seq_q.st == SS_HOLD)) |-> (applied_demand >= FLOOR_V));

    p_ramp_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q.st == SS_RAMP) && ($past(seq_q.st) == SS_RAMP))
        |-> (applied_demand <= $past(applied_demand))
            && (applied_demand + 1'b1 >= $past(applied_demand)));

    p_lock_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SS_LOCK) |-> (!drive_en && applied_demand == '0));

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drive_en && applied_demand == '0));
endmodule

// File: tb/tb_ss_softstart_seq.sv
module tb_ss_softstart_seq;
    localparam int DEM_W = 9, ILIM_W = 6, ILIM_START = 2, ILIM_MAX = 8;
    localparam int SLOW_MS = 6, FAST_MS = 3, HOLD_MS = 10, STEP_MS = 2, LOCK_MS = 20, FLOOR = 256;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fast_sel = 1'b0;
    logic mode_sw = 1'b0, lock_det = 1'b0, ms_tick = 1'b0;
    logic [DEM_W-1:0]  ext_demand = '0;
    logic [DEM_W-1:0]  applied_demand;
    logic [ILIM_W-1:0] ilim_code;
    logic              drive_en;
    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ss_softstart_seq #(
        .DEM_W(DEM_W), .ILIM_W(ILIM_W), .ILIM_START(ILIM_START), .ILIM_MAX(ILIM_MAX),
        .SLOW_MS(SLOW_MS), .FAST_MS(FAST_MS), .HOLD_MS(HOLD_MS), .STEP_MS(STEP_MS),
        .LOCK_MS(LOCK_MS), .FLOOR(FLOOR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .fast_sel(fast_sel), .ext_demand(ext_demand),
        .mode_sw(mode_sw), .lock_det(lock_det), .ms_tick(ms_tick),
        .applied_demand(applied_demand), .ilim_code(ilim_code), .drive_en(drive_en)
    );

    function automatic int floor_of(int ext);
        return (ext > FLOOR) ? ext : FLOOR;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic pulse_mode();
        @(negedge clk) mode_sw = 1'b1;
        @(negedge clk) mode_sw = 1'b0;
    endtask

    task automatic pulse_lock();
        @(negedge clk) lock_det = 1'b1;
        @(negedge clk) lock_det = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int e;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 demand", applied_demand, 0);
        chk("R8 drive", drive_en, 0);
        chk("R8 ilim", ilim_code, ILIM_START);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle after release", drive_en, 0);

        // R7/R3 start, floor applied to a low demand
        ext_demand = 9'd100;
        en = 1'b1;
        @(negedge clk);
        chk("R7 start drive", drive_en, 1);
        chk("R3 floor", applied_demand, FLOOR);
        chk("R1 start code", ilim_code, ILIM_START);

        // R1 slow schedule
        ticks(SLOW_MS - 1);
        chk("R1 before step", ilim_code, ILIM_START);
        ticks(1);
        chk("R1 slow step", ilim_code, ILIM_START + 1);

        // R3 high demand passes through
        @(negedge clk) ext_demand = 9'd400;
        @(negedge clk);
        chk("R3 pass high", applied_demand, 400);
        ext_demand = 9'd100;
        @(negedge clk);
        chk("R3 back to floor", applied_demand, FLOOR);

        // R2 cap
        ticks(SLOW_MS * (ILIM_MAX - ILIM_START) + 10);
        chk("R2 cap", ilim_code, ILIM_MAX);

        // R4 hold then ramp
        pulse_mode();
        chk("R3 hold floor", applied_demand, FLOOR);
        ticks(HOLD_MS + STEP_MS - 1);
        chk("R4 no step yet", applied_demand, FLOOR);
        ticks(1);
        chk("R4 first step", applied_demand, FLOOR - 1);
        ticks(STEP_MS);
        chk("R4 second step", applied_demand, FLOOR - 2);

        // R5 external rises above ramp
        @(negedge clk) ext_demand = 9'd300;
        @(negedge clk);
        chk("R5 jump to ext", applied_demand, 300);
        for (int k = 0; k < 20; k++) begin
            e = $urandom_range(511, 0);
            @(negedge clk) ext_demand = DEM_W'(e);
            @(negedge clk);
            chk("R5 run tracks", applied_demand, e);
        end

        // R6 lockout with a repeated flag ignored
        ext_demand = 9'd300;
        pulse_lock();
        chk("R6 drive off", drive_en, 0);
        chk("R6 demand zero", applied_demand, 0);
        ticks(5);
        pulse_lock();
        ticks(LOCK_MS - 6);
        chk("R6 still off", drive_en, 0);
        fast_sel = 1'b1;
        ticks(1);
        chk("R6 restart drive", drive_en, 1);
        chk("R6 restart demand", applied_demand, 300);
        chk("R6 restart ilim", ilim_code, ILIM_START);

        // R1 fast schedule
        ticks(FAST_MS - 1);
        chk("R1 fast before", ilim_code, ILIM_START);
        ticks(1);
        chk("R1 fast step", ilim_code, ILIM_START + 1);

        // R4/R5 full ramp to a demand below the floor
        ext_demand = 9'd250;
        @(negedge clk);
        pulse_mode();
        ticks(HOLD_MS);
        chk("R4 ramp entry", applied_demand, FLOOR);
        ticks(STEP_MS * (FLOOR - 250));
        chk("R4 ramp end", applied_demand, 250);
        ticks(4);
        chk("R5 settled", applied_demand, 250);
        @(negedge clk) ext_demand = 9'd50;
        @(negedge clk);
        chk("R5 run below floor", applied_demand, 50);

        // R7 disable
        @(negedge clk) en = 1'b0;
        @(negedge clk);
        chk("R7 off drive", drive_en, 0);
        chk("R7 off demand", applied_demand, 0);
        @(negedge clk);
        chk("R7 off ilim", ilim_code, ILIM_START);

        // R3/R7 random restarts
        for (int k = 0; k < 10; k++) begin
            e = $urandom_range(511, 0);
            @(negedge clk) ext_demand = DEM_W'(e);
            en = 1'b1;
            @(negedge clk);
            chk("R3 random start", applied_demand, floor_of(e));
            ticks($urandom_range(3, 0));
            @(negedge clk) en = 1'b0;
            @(negedge clk);
            chk("R7 random stop", applied_demand, 0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule